// File: doc/BRIEF.md
# Receive Input Crossbar and Frame Packer

This block sits between the analog-to-digital converters and the digital downconverter channels on the receive path. A single 32-bit configuration word gives each of the four channels a 2-bit selector for its I input and one for its Q input. Each selector picks one of four ADC sample streams. A single override bit forces every Q input to zero, for real-only reception. This crossbar is purely combinational.

On the output side, the block waits for a strobe that marks a new set of complex channel outputs. When the strobe arrives, it captures those outputs into a small holding register. It then sends them as a stream of 16-bit words over a valid/ready handshake. The channel-count field of the same configuration word sets how many channels make up one frame.

If a strobe arrives while a frame is still being sent, that strobe is dropped and a sticky overrun flag is raised.

Top module: `rx_route_pack`

## Requirements
- R1: Channel c takes its I selector from `cfg_word[4c+5:4c+4]` and its Q selector from `cfg_word[4c+7:4c+6]`. Selector value n routes `adc_samples[16n+15:16n]` to that input. Routing is combinational, and channel c occupies bits `[16c+15:16c]` of `ddc_i_in` and `ddc_q_in`.
- R2: When `cfg_word[3]` is 1, every channel's Q input is zero, whatever the Q selectors hold.
- R3: `cfg_word[2:0]` gives the channel count. The values 1, 2 and 4 give frames of 2, 4 and 8 words. Any other value is treated as 1 channel (2 words).
- R4: Within a frame, words leave in the order channel 0 I, channel 0 Q, channel 1 I, channel 1 Q, and so on. The data are the values of `chan_i_out` and `chan_q_out` at the capturing edge.
- R5: A `chan_strobe` sampled high while `host_valid` is low captures a frame. From the next cycle on, `host_valid` is high and `host_data` carries word 0.
- R6: While `host_valid` is high and `host_ready` is low, `host_data` holds its value. Each cycle with both high advances to the next word. `host_valid` falls in the cycle after the last word's handshake.
- R7: A `chan_strobe` sampled while `host_valid` is high is dropped: the frame in flight continues unchanged. The same strobe sets `overrun`, which stays set until reset.
- R8: During and after reset, `host_valid` and `overrun` are 0.
- R9: `cfg_word[31:20]` has no effect on routing or framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_samples | input | 64 | Four ADC samples, ADC n in bits 16n+15:16n |
| cfg_word | input | 32 | Routing and framing configuration |
| ddc_i_in | output | 64 | Routed I inputs, channel c in bits 16c+15:16c |
| ddc_q_in | output | 64 | Routed Q inputs, channel c in bits 16c+15:16c |
| chan_i_out | input | 64 | Channel I outputs, channel c in bits 16c+15:16c |
| chan_q_out | input | 64 | Channel Q outputs, channel c in bits 16c+15:16c |
| chan_strobe | input | 1 | New channel outputs available |
| host_ready | input | 1 | Host accepts the current word |
| host_valid | output | 1 | A word is on host_data |
| host_data | output | 16 | Frame word |
| overrun | output | 1 | Sticky: a strobe was dropped |

## Verification
Several rules are checked by assertions on every cycle:
- the Q inputs are zero under the override;
- a word is held while the host stalls;
- an idle strobe starts a frame;
- a busy strobe raises overrun, and overrun never clears;
- the word index stays inside the frame length.

Some behaviour only the bench scenarios can show. These are:
- the selector field positions and the ADC each value picks;
- the exact word order and word count for each channel count, including illegal values;
- the falling edge of valid after the last word;
- that a dropped strobe leaves the frame in flight untouched;
- that the upper configuration bits are ignored.

// File: rtl/rx_route_pkg.sv
// Shared constants and helpers for the receive crossbar and packer.
// Assumes the fixed configuration word layout: count, Q-zero bit, 2-bit selectors.
package rx_route_pkg;
    localparam int NUM_ADC   = 4;
    localparam int NUM_CHAN  = 4;
    localparam int SEL_W     = 2;
    localparam int CNT_W     = 3;
    localparam int ZERO_BIT  = 3;
    localparam int SEL_LSB   = 4;
    localparam int SEL_BITS  = 2 * SEL_W * NUM_CHAN;
    localparam int MAX_WORDS = 2 * NUM_CHAN;

    // Map the count field to a channel count; illegal codes mean one channel.
    function automatic int unsigned chan_count(input logic [CNT_W-1:0] code);
        case (code)
            3'd2:    return 2;
            3'd4:    return 4;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/rx_input_xbar.sv
// Combinational crossbar: routes any ADC stream to each channel's I and Q input.
// Assumes selector pairs packed per channel as {Q sel, I sel}, channel 0 lowest.
module rx_input_xbar
    import rx_route_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [NUM_ADC*SAMPLE_W-1:0]  adc_samples,
    input  logic [SEL_BITS-1:0]          sel_field,
    input  logic                         zero_q,
    output logic [NUM_CHAN*SAMPLE_W-1:0] ddc_i,
    output logic [NUM_CHAN*SAMPLE_W-1:0] ddc_q
);
    localparam int PAIR_W = 2 * SEL_W;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic [SEL_W-1:0] sel_i;
        logic [SEL_W-1:0] sel_q;
        assign sel_i = sel_field[c*PAIR_W +: SEL_W];
        assign sel_q = sel_field[c*PAIR_W + SEL_W +: SEL_W];

        // Pick the ADC for I, and for Q unless the zero override is on.
        always_comb begin
            ddc_i[c*SAMPLE_W +: SAMPLE_W] = adc_samples[int'(sel_i)*SAMPLE_W +: SAMPLE_W];
            if (zero_q)
                ddc_q[c*SAMPLE_W +: SAMPLE_W] = '0;
            else
                ddc_q[c*SAMPLE_W +: SAMPLE_W] = adc_samples[int'(sel_q)*SAMPLE_W +: SAMPLE_W];
        end
    end
endmodule

// File: rtl/rx_frame_packer.sv
// Captures one complex sample per channel on a strobe and sends them as
// I/Q interleaved words over valid/ready. Assumes strobes are single-cycle;
// a strobe while busy is dropped and flagged.
module rx_frame_packer
    import rx_route_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             cnt_code,
    input  logic [NUM_CHAN*SAMPLE_W-1:0] chan_i,
    input  logic [NUM_CHAN*SAMPLE_W-1:0] chan_q,
    input  logic                         chan_strobe,
    input  logic                         host_ready,
    output logic                         host_valid,
    output logic [SAMPLE_W-1:0]          host_data,
    output logic                         overrun
);
    localparam int IDX_W = $clog2(MAX_WORDS);

    logic [SAMPLE_W-1:0] hold_q [MAX_WORDS];
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    last_q;
    logic                busy_q;
    logic                take;

    assign take = chan_strobe && !busy_q;

    // Capture all channel outputs into the holding register on an accepted strobe.
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_hold
        always_ff @(posedge clk) begin
            if (take) begin
                hold_q[2*c]   <= chan_i[c*SAMPLE_W +: SAMPLE_W];
                hold_q[2*c+1] <= chan_q[c*SAMPLE_W +: SAMPLE_W];
            end
        end
    end

    // Frame sequencing: start on accepted strobe, step on handshake, stop after last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            last_q <= IDX_W'(2 * chan_count(cnt_code) - 1);
        end else if (busy_q && host_ready) begin
            if (idx_q == last_q) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Sticky flag for strobes that arrive during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (chan_strobe && busy_q)
            overrun <= 1'b1;
    end

    assign host_valid = busy_q;
    assign host_data  = hold_q[idx_q];

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && !host_ready |=> host_valid && $stable(host_data)); // R6
    AST_START_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        chan_strobe && !host_valid |=> host_valid); // R5
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        chan_strobe && host_valid |=> overrun); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R7
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> idx_q <= last_q); // R3
endmodule

// File: rtl/rx_route_pack.sv
// Top: ADC-to-channel crossbar plus channel-to-host frame packer,
// both steered by one configuration word whose bits 31:20 are ignored.
module rx_route_pack
    import rx_route_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_ADC*SAMPLE_W-1:0]  adc_samples,
    input  logic [31:0]                  cfg_word,
    output logic [NUM_CHAN*SAMPLE_W-1:0] ddc_i_in,
    output logic [NUM_CHAN*SAMPLE_W-1:0] ddc_q_in,
    input  logic [NUM_CHAN*SAMPLE_W-1:0] chan_i_out,
    input  logic [NUM_CHAN*SAMPLE_W-1:0] chan_q_out,
    input  logic                         chan_strobe,
    input  logic                         host_ready,
    output logic                         host_valid,
    output logic [SAMPLE_W-1:0]          host_data,
    output logic                         overrun
);
    logic unused_cfg_hi;
    assign unused_cfg_hi = ^cfg_word[31:SEL_LSB+SEL_BITS];

    rx_input_xbar #(.SAMPLE_W(SAMPLE_W)) u_xbar (
        .adc_samples (adc_samples),
        .sel_field   (cfg_word[SEL_LSB +: SEL_BITS]),
        .zero_q      (cfg_word[ZERO_BIT]),
        .ddc_i       (ddc_i_in),
        .ddc_q       (ddc_q_in)
    );

    rx_frame_packer #(.SAMPLE_W(SAMPLE_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_code    (cfg_word[CNT_W-1:0]),
        .chan_i      (chan_i_out),
        .chan_q      (chan_q_out),
        .chan_strobe (chan_strobe),
        .host_ready  (host_ready),
        .host_valid  (host_valid),
        .host_data   (host_data),
        .overrun     (overrun)
    );

    AST_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[ZERO_BIT] |-> ddc_q_in == '0); // R2
endmodule

// File: tb/tb_rx_route_pack.sv
module tb_rx_route_pack;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   adc_samples = '0;
    logic [31:0]   cfg_word = '0;
    logic [63:0]   ddc_i_in, ddc_q_in;
    logic [63:0]   chan_i_out = '0, chan_q_out = '0;
    logic          chan_strobe = 1'b0, host_ready = 1'b0;
    logic          host_valid, overrun;
    logic [W-1:0]  host_data;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    rx_route_pack #(.SAMPLE_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .adc_samples(adc_samples), .cfg_word(cfg_word),
        .ddc_i_in(ddc_i_in), .ddc_q_in(ddc_q_in), .chan_i_out(chan_i_out),
        .chan_q_out(chan_q_out), .chan_strobe(chan_strobe), .host_ready(host_ready),
        .host_valid(host_valid), .host_data(host_data), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected routed input for channel c (R1, R2).
    function automatic logic [W-1:0] exp_route(input logic [63:0] adc, input logic [31:0] cfg,
                                               input int c, input bit is_q);
        logic [1:0] s;
        s = is_q ? cfg[4*c+6 +: 2] : cfg[4*c+4 +: 2];
        if (is_q && cfg[3]) return '0;
        return adc[16*s +: 16];
    endfunction

    // Channels per frame from the count code (R3).
    function automatic int exp_chans(input logic [2:0] code);
        return (code == 3'd2) ? 2 : (code == 3'd4) ? 4 : 1;
    endfunction

    task automatic check_route(input logic [31:0] cfg, input logic [63:0] adc);
        logic [63:0] ei, eq, ri, rq;
        for (int c = 0; c < 4; c++) begin
            ei[16*c +: 16] = exp_route(adc, cfg, c, 1'b0);
            eq[16*c +: 16] = exp_route(adc, cfg, c, 1'b1);
        end
        cfg_word = {12'h000, cfg[19:0]};
        adc_samples = adc;
        #1;
        ri = ddc_i_in; rq = ddc_q_in;
        check(ddc_i_in === ei, "R1 I routing", ddc_i_in, ei);
        check(ddc_q_in === eq, cfg[3] ? "R2 Q zero" : "R1 Q routing", ddc_q_in, eq);
        cfg_word = {cfg[31:20] | 12'h001, cfg[19:0]};
        #1;
        check(ddc_i_in === ri && ddc_q_in === rq, "R9 upper bits ignored", ddc_i_in, ri);
    endtask

    // Send one frame with random stalls; optionally inject a strobe mid-frame (R7).
    task automatic send_frame(input logic [2:0] code, input bit inject);
        logic [W-1:0] exp [8];
        int words, n, guard, bad;
        logic [W-1:0] bad_act, bad_exp;
        bit r, done_inj;
        words = 2 * exp_chans(code);
        @(negedge clk);
        cfg_word = {$urandom} & 32'h000F_FFF8 | {29'd0, code} | 32'hABC0_0000;
        chan_i_out = {$urandom, $urandom};
        chan_q_out = {$urandom, $urandom};
        for (int c = 0; c < 4; c++) begin
            exp[2*c]   = chan_i_out[16*c +: 16];
            exp[2*c+1] = chan_q_out[16*c +: 16];
        end
        chan_strobe = 1'b1;
        @(negedge clk);
        chan_strobe = 1'b0;
        chan_i_out = ~chan_i_out;
        chan_q_out = ~chan_q_out;
        check(host_valid === 1'b1 && host_data === exp[0], "R5 frame start", {host_valid, host_data}, {1'b1, exp[0]});
        n = 0; guard = 0; bad = 0; done_inj = 0; bad_act = '0; bad_exp = '0;
        while (n < words && guard < 2000) begin
            guard++;
            if (host_valid !== 1'b1 || host_data !== exp[n]) begin
                if (bad == 0) begin bad_act = host_data; bad_exp = exp[n]; end
                bad++;
            end
            if (inject && !done_inj && n == 1) begin
                host_ready = 1'b0;
                chan_i_out = {$urandom, $urandom};
                chan_strobe = 1'b1;
                done_inj = 1;
                @(negedge clk);
                chan_strobe = 1'b0;
            end else begin
                r = ($urandom % 3) != 0;
                host_ready = r;
                @(negedge clk);
                if (r) n++;
            end
        end
        host_ready = 1'b0;
        check(bad == 0, "R4 word order", bad_act, bad_exp);
        check(host_valid === 1'b0, "R6 valid falls after last word", host_valid, 0);
        if (inject)
            check(overrun === 1'b1, "R7 overrun set", overrun, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(host_valid === 1'b0 && overrun === 1'b0, "R8 reset state", {host_valid, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_valid === 1'b0 && overrun === 1'b0, "R8 after reset", {host_valid, overrun}, 0);

        // Directed crossbar corners.
        check_route(32'h0000_0000, 64'h4444_3333_2222_1111);
        check_route(32'h000F_FFF0, 64'h4444_3333_2222_1111);
        check_route(32'h000F_FFF8, 64'h4444_3333_2222_1111);
        check_route(32'h0001_B1E0, 64'hDDDD_CCCC_BBBB_AAAA);
        for (int i = 0; i < 40; i++) check_route($urandom, {$urandom, $urandom});

        // Stall behaviour check at the port (R6).
        send_frame(3'd4, 1'b0);
        send_frame(3'd1, 1'b0);
        send_frame(3'd2, 1'b0);
        send_frame(3'd0, 1'b0);   // illegal, treated as 1 (R3)
        send_frame(3'd7, 1'b0);   // illegal, treated as 1 (R3)
        send_frame(3'd3, 1'b0);   // illegal, treated as 1 (R3)
        for (int i = 0; i < 20; i++) begin
            logic [2:0] cd;
            cd = 3'($urandom);
            send_frame(cd, 1'b0);
        end
        check(overrun === 1'b0, "R7 no overrun when idle strobes", overrun, 0);

        // Overrun: dropped strobe, frame intact, flag sticky.
        send_frame(3'd4, 1'b1);
        send_frame(3'd2, 1'b0);
        check(overrun === 1'b1, "R7 overrun sticky", overrun, 1);

        // Reset clears overrun.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(overrun === 1'b0 && host_valid === 1'b0, "R8 reset clears", {host_valid, overrun}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule